// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block takes one 32-bit block-transfer instruction and expands it into a stream of simple micro-operations. The stream goes out one per cycle on a valid/ready handshake. The instruction carries a 16-bit register list in bits 15:0, a base register number in bits 19:16, and five mode bits in bits 24:20. Read from high to low, the mode bits are pre/post (bit 24), up/down (bit 23), an unused user bit (bit 22), writeback (bit 21) and load/store (bit 20).

Each stream begins with a micro-op that copies the base register into a scratch base. One transfer micro-op follows for every set bit of the list, and each transfer names a register and a byte offset from the base. When the writeback bit is set, an add or subtract micro-op closes the stream and updates the base by four times the register count. The final micro-op of every stream carries a last flag.

A mode that is not on the supported list produces a one-cycle error pulse and no micro-ops. Memory access, register-file writes, banked-register handling and condition evaluation belong to other blocks.

Top module: `lsm_uop_seq`

## Requirements
- R1: An accepted supported instruction emits exactly N+1+W micro-ops, where N is the number of set bits in bits 15:0 and W is bit 21. After the final handshake `uop_valid` is low.
- R2: The first micro-op has kind BASE (0), word `{instr[31:16], 16'h0000}`, register 0 and offset 0.
- R3: The transfer micro-ops visit the set list bits in ascending index order, with `uop_reg` equal to that index and word 0. Their kind is LOAD (1) when bit 20 is set and STORE (2) when it is clear.
- R4: The mode value is instr[24:20]. The first transfer's offset is 4N-4 for modes 0x01 and 0x03, 0 for modes 0x08, 0x09 and 0x0B, 4N for modes 0x11 and 0x12, and 4 for modes 0x18 and 0x19.
- R5: Each later transfer's offset is the previous one plus 4 when bit 23 is set, and minus 4 when it is clear. Offsets are 8 bits wide.
- R6: The writeback word is `{instr[31:28], 28'h0}` OR 0x02400000 OR (base << 16) OR (base << 12) OR 4N, where base is instr[19:16].
- R7: The writeback micro-op has kind ADD (3) when bit 23 is set and SUB (4) when it is clear. It is always the last micro-op. `uop_last` is high on the final micro-op of a stream and on no other.
- R8: For any mode value outside the nine listed, `err_pulse` is high for exactly the one cycle after acceptance, and no micro-op is emitted.
- R9: `in_ready` is high only while no micro-op is pending. An instruction is taken when `in_valid` and `in_ready` are both high.
- R10: While `uop_valid` is high and `uop_ready` is low, all micro-op outputs hold their values.
- R11: An empty list with bit 21 clear emits one BASE micro-op with `uop_last` high.
- R12: After reset, `uop_valid` and `err_pulse` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction can be taken |
| in_instr | input | 32 | Block-transfer instruction word |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_kind | output | 3 | 0 BASE, 1 LOAD, 2 STORE, 3 ADD, 4 SUB |
| uop_word | output | 32 | Synthesized instruction word (BASE and writeback) |
| uop_reg | output | 4 | Register index of a transfer |
| uop_offset | output | 8 | Byte offset of a transfer |
| uop_last | output | 1 | Final micro-op of the stream |
| err_pulse | output | 1 | Unsupported mode detected |

## Verification
The bench sweeps all 32 mode values against a set of register lists: empty, lowest bit only, highest bit only, both ends, full, and two sparse patterns. Together these separate the start offset of each mode, the direction of the step and the ascending scan order. The empty and single-register lists expose errors in the last-flag and count logic, and the full list exercises the maximum immediate of 64 in the writeback word. Some of the runs hold back `uop_ready`, which shows whether the outputs stay put under backpressure.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [2:0] {
        K_BASE  = 3'd0,
        K_LOAD  = 3'd1,
        K_STORE = 3'd2,
        K_ADD   = 3'd3,
        K_SUB   = 3'd4
    } uop_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BASE = 2'd1,
        PH_XFER = 2'd2,
        PH_WB   = 2'd3
    } phase_e;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] count
);
    logic [CW-1:0] part [W+1];

    assign part[0] = '0;
    for (genvar i = 0; i < W; i++) begin : g_sum
        assign part[i+1] = part[i] + CW'(bits[i]);
    end
    assign count = part[W];
endmodule

// File: rtl/lsm_low_pick.sv
module lsm_low_pick #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot,
    output logic          single
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits[i]) idx = IW'(i);
        end
    end

    assign onehot = bits & (~bits + W'(1));
    assign single = (bits != '0) && ((bits & (bits - W'(1))) == '0);
endmodule

// File: rtl/lsm_mode_decode.sv
module lsm_mode_decode #(
    parameter int CW    = 5,
    parameter int OFF_W = 8
) (
    input  logic [4:0]       mode,
    input  logic [CW-1:0]    count,
    output logic             legal,
    output logic [OFF_W-1:0] start_off,
    output logic             up,
    output logic             wb,
    output logic             load
);
    logic [OFF_W-1:0] four_n;

    assign four_n = OFF_W'(count) << 2;
    assign up     = mode[3];
    assign wb     = mode[1];
    assign load   = mode[0];

    always_comb begin
        legal     = 1'b1;
        start_off = '0;
        case (mode)
            5'h01, 5'h03:        start_off = four_n - OFF_W'(4);
            5'h08, 5'h09, 5'h0B: start_off = '0;
            5'h11, 5'h12:        start_off = four_n;
            5'h18, 5'h19:        start_off = OFF_W'(4);
            default:             legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsm_wb_encode.sv
module lsm_wb_encode #(
    parameter int CW = 5
) (
    input  logic [15:0]   hi,
    input  logic [CW-1:0] count,
    output logic [31:0]   word
);
    logic [31:0] rn_w;

    assign rn_w = {28'h0, hi[3:0]};
    assign word = {hi[15:12], 28'h0} | 32'h0240_0000
                | (rn_w << 16) | (rn_w << 12) | (32'(count) << 2);
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_pkg::*;
#(
    parameter int LIST_W = 16,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_instr,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [2:0]        uop_kind,
    output logic [31:0]       uop_word,
    output logic [3:0]        uop_reg,
    output logic [OFF_W-1:0]  uop_offset,
    output logic              uop_last,
    output logic              err_pulse
);
    localparam int CW = $clog2(LIST_W + 1);
    localparam int IW = $clog2(LIST_W);

    typedef struct packed {
        phase_e            phase;
        logic [LIST_W-1:0] rem;
        logic [OFF_W-1:0]  off;
        logic              up;
        logic              wb;
        logic              load;
        logic              err;
        logic [15:0]       hi;
        logic [CW-1:0]     cnt;
    } seq_t;

    seq_t st_q, st_d;

    logic [CW-1:0]     in_cnt;
    logic              dec_legal, dec_up, dec_wb, dec_load;
    logic [OFF_W-1:0]  dec_off;
    logic [IW-1:0]     pick_idx;
    logic [LIST_W-1:0] pick_oh;
    logic              pick_single;
    logic [31:0]       wb_word;
    logic              fire;
    logic [LIST_W-1:0] rem_next;

    lsm_popcount #(.W(LIST_W), .CW(CW)) u_pop (
        .bits  (in_instr[LIST_W-1:0]),
        .count (in_cnt)
    );

    lsm_mode_decode #(.CW(CW), .OFF_W(OFF_W)) u_dec (
        .mode      (in_instr[24:20]),
        .count     (in_cnt),
        .legal     (dec_legal),
        .start_off (dec_off),
        .up        (dec_up),
        .wb        (dec_wb),
        .load      (dec_load)
    );

    lsm_low_pick #(.W(LIST_W), .IW(IW)) u_pick (
        .bits   (st_q.rem),
        .idx    (pick_idx),
        .onehot (pick_oh),
        .single (pick_single)
    );

    lsm_wb_encode #(.CW(CW)) u_wb (
        .hi    (st_q.hi),
        .count (st_q.cnt),
        .word  (wb_word)
    );

    // outputs decoded from the current phase
    always_comb begin
        uop_valid  = 1'b0;
        uop_kind   = K_BASE;
        uop_word   = '0;
        uop_reg    = '0;
        uop_offset = '0;
        uop_last   = 1'b0;
        case (st_q.phase)
            PH_BASE: begin
                uop_valid = 1'b1;
                uop_word  = {st_q.hi, 16'h0000};
                uop_last  = (st_q.rem == '0) && !st_q.wb;
            end
            PH_XFER: begin
                uop_valid  = 1'b1;
                uop_kind   = st_q.load ? K_LOAD : K_STORE;
                uop_reg    = 4'(pick_idx);
                uop_offset = st_q.off;
                uop_last   = pick_single && !st_q.wb;
            end
            PH_WB: begin
                uop_valid = 1'b1;
                uop_kind  = st_q.up ? K_ADD : K_SUB;
                uop_word  = wb_word;
                uop_last  = 1'b1;
            end
            default: ;
        endcase
    end

    assign in_ready  = (st_q.phase == PH_IDLE);
    assign err_pulse = st_q.err;
    assign fire      = uop_valid && uop_ready;
    assign rem_next  = st_q.rem & ~pick_oh;

    // next-state computation
    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    if (dec_legal) begin
                        st_d.phase = PH_BASE;
                        st_d.rem   = in_instr[LIST_W-1:0];
                        st_d.off   = dec_off;
                        st_d.up    = dec_up;
                        st_d.wb    = dec_wb;
                        st_d.load  = dec_load;
                        st_d.hi    = in_instr[31:16];
                        st_d.cnt   = in_cnt;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
            end
            PH_BASE: begin
                if (fire) begin
                    if (st_q.rem != '0) st_d.phase = PH_XFER;
                    else if (st_q.wb)   st_d.phase = PH_WB;
                    else                st_d.phase = PH_IDLE;
                end
            end
            PH_XFER: begin
                if (fire) begin
                    st_d.rem = rem_next;
                    st_d.off = st_q.up ? st_q.off + OFF_W'(4)
                                       : st_q.off - OFF_W'(4);
                    if (rem_next == '0)
                        st_d.phase = st_q.wb ? PH_WB : PH_IDLE;
                end
            end
            PH_WB: begin
                if (fire) st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk
    import lsm_pkg::*;
#(
    parameter int OFF_W  = 8,
    parameter int LIST_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             uop_valid,
    input logic             uop_ready,
    input logic [2:0]       uop_kind,
    input logic [31:0]      uop_word,
    input logic [3:0]       uop_reg,
    input logic [OFF_W-1:0] uop_offset,
    input logic             uop_last,
    input logic             err_pulse
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_kind)
            && $stable(uop_word) && $stable(uop_reg)
            && $stable(uop_offset) && $stable(uop_last));

    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> (uop_valid != err_pulse));

    assert_err_no_uop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !uop_valid);

    assert_wb_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && (uop_kind == K_ADD || uop_kind == K_SUB) |-> uop_last);

    assert_stream_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_ready && uop_last |=> !uop_valid);

    assert_off_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && (uop_kind == K_LOAD || uop_kind == K_STORE)
            |-> uop_offset <= OFF_W'(4 * LIST_W));
endmodule

bind lsm_uop_seq lsm_uop_seq_chk #(.OFF_W(OFF_W), .LIST_W(LIST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .uop_valid  (uop_valid),
    .uop_ready  (uop_ready),
    .uop_kind   (uop_kind),
    .uop_word   (uop_word),
    .uop_reg    (uop_reg),
    .uop_offset (uop_offset),
    .uop_last   (uop_last),
    .err_pulse  (err_pulse)
);

// File: tb/lsm_uop_seq_bench.sv
module lsm_uop_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic        uop_valid;
    logic        uop_ready = 1'b0;
    logic [2:0]  uop_kind;
    logic [31:0] uop_word;
    logic [3:0]  uop_reg;
    logic [7:0]  uop_offset;
    logic        uop_last;
    logic        err_pulse;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lsm_uop_seq u_lsm_uop_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_kind(uop_kind), .uop_word(uop_word), .uop_reg(uop_reg),
        .uop_offset(uop_offset), .uop_last(uop_last), .err_pulse(err_pulse)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit mode_ok(input logic [4:0] m);
        return m == 5'h01 || m == 5'h03 || m == 5'h08 || m == 5'h09 ||
               m == 5'h0B || m == 5'h11 || m == 5'h12 || m == 5'h18 ||
               m == 5'h19;
    endfunction

    task automatic run(input logic [31:0] ins, input bit stall);
        logic [4:0]  m;
        logic [15:0] rem;
        int          n;
        bit          up, wb, ld;
        logic [7:0]  off;
        int          total;
        logic [31:0] wbw;
        m   = ins[24:20];
        rem = ins[15:0];
        n   = $countones(ins[15:0]);
        up  = m[3];
        wb  = m[1];
        ld  = m[0];
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 idle ready", 32'(in_ready), 32'd1);
        in_valid = 1'b1;
        in_instr = ins;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (!mode_ok(m)) begin
            chk(err_pulse == 1'b1 && !uop_valid, "R8 error pulse",
                {30'd0, err_pulse, uop_valid}, 32'd2);
            @(negedge clk);
            chk(err_pulse == 1'b0 && !uop_valid, "R8 pulse ends",
                {30'd0, err_pulse, uop_valid}, 32'd0);
            return;
        end
        case (m)
            5'h01, 5'h03: off = 8'(4 * n - 4);
            5'h11, 5'h12: off = 8'(4 * n);
            5'h18, 5'h19: off = 8'd4;
            default:      off = 8'd0;
        endcase
        total = n + 1 + int'(wb);
        wbw = {ins[31:28], 28'h0} | 32'h0240_0000 | (32'(ins[19:16]) << 16)
            | (32'(ins[19:16]) << 12) | 32'(4 * n);
        for (int k = 0; k < total; k++) begin
            bit last_e;
            last_e = (k == total - 1);
            chk(uop_valid == 1'b1, "R1 valid", 32'(uop_valid), 32'd1);
            chk(in_ready == 1'b0, "R9 busy", 32'(in_ready), 32'd0);
            chk(uop_last == last_e, (total == 1 && !wb) ? "R11 last" : "R7 last",
                32'(uop_last), 32'(last_e));
            if (k == 0) begin
                chk(uop_kind == 3'd0 && uop_word == {ins[31:16], 16'h0},
                    "R2 base copy", uop_word, {ins[31:16], 16'h0});
            end else if (k <= n) begin
                int j;
                j = 0;
                while (!rem[j]) j++;
                rem[j] = 1'b0;
                chk(uop_kind == (ld ? 3'd1 : 3'd2) && uop_reg == 4'(j)
                    && uop_word == 0, "R3 transfer",
                    {25'd0, uop_kind, uop_reg}, {25'd0, (ld ? 3'd1 : 3'd2), 4'(j)});
                chk(uop_offset == off, (k == 1) ? "R4 start offset" : "R5 step",
                    32'(uop_offset), 32'(off));
                off = up ? off + 8'd4 : off - 8'd4;
            end else begin
                chk(uop_kind == (up ? 3'd3 : 3'd4), "R7 wb kind",
                    32'(uop_kind), (up ? 32'd3 : 32'd4));
                chk(uop_word == wbw, "R6 wb word", uop_word, wbw);
            end
            if (stall) begin
                logic [31:0] w0;
                logic [7:0]  o0;
                w0 = uop_word;
                o0 = uop_offset;
                @(negedge clk);
                chk(uop_valid && uop_word == w0 && uop_offset == o0,
                    "R10 hold", uop_word, w0);
            end
            uop_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            uop_ready = 1'b0;
        end
        chk(uop_valid == 1'b0, "R1 stream done", 32'(uop_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lists [7];
        lists = '{16'h0000, 16'h0001, 16'h8000, 16'h8001,
                  16'hFFFF, 16'h0A5A, 16'h0124};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!uop_valid && in_ready && !err_pulse, "R12 reset",
            {29'd0, uop_valid, in_ready, err_pulse}, 32'd2);
        rst_n = 1'b1;
        for (int m = 0; m < 32; m++) begin
            for (int li = 0; li < 7; li++) begin
                logic [31:0] ins;
                ins = {4'(m + li), 3'b100, 5'(m), 4'(m ^ li), lists[li]};
                run(ins, ((m + li) % 3) == 0);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule